// File: doc/BRIEF.md
# Bus Parity Generator with One-Shot Fault Injection

This block sits between an on-chip bus controller and the bus drivers. It computes even, byte-wise parity for a 36-bit address bus and a 128-bit data bus. On request it deliberately corrupts chosen parity bits so that software error handlers can be tested. Address and data injection each have their own pair of registers. The mask register names the parity bits to invert. The control register holds the source ID to match and an arm bit.

An armed channel fires exactly once. The address channel fires on the address cycle of a transaction whose source ID matches. The data channel fires on the first beat of a data burst whose source ID matches. For a write the source is the writing master. For a read completion it is the responding agent. The parity outputs are combinational, so the fault appears in the same cycle as the transaction. The arm bit clears on the following clock edge.

Each injection channel is a two-state machine. `ARM_IDLE` goes to `ARM_LIVE` on a control write with the arm bit set. `ARM_LIVE` goes back to `ARM_IDLE` on a control write with the arm bit clear, or when it fires. A control write made in the same cycle as a fire takes priority. A beat tracker with states `BEAT_FIRST` and `BEAT_REST` finds the first data beat. `BEAT_FIRST` goes to `BEAT_REST` on a data beat without `txn_last`. `BEAT_REST` goes back to `BEAT_FIRST` on a data beat with `txn_last`. A single-beat burst stays in `BEAT_FIRST`.

Top module: `bus_parity_injector`

## Requirements
- R1: `addr_par[k]` for k in 0..3 is the XOR of `txn_addr[8k+7:8k]`. `addr_par[4]` is the XOR of `txn_addr[35:32]` (even parity).
- R2: `data_par[k]` for k in 0..15 is the XOR of `txn_data[8k+7:8k]` (even parity).
- R3: The registers are at these `reg_addr` values: 0 is the address mask (bits 4:0), 1 is the address control, 2 is the data mask (bits 15:0) and 3 is the data control. A control register holds the arm bit at bit 0 and the source ID at bits 12:8. All registers read back through `reg_rdata` and reset to zero.
- R4: The address channel fires in a cycle when it is armed, `txn_valid`=1, `txn_is_data`=0 and `txn_src` equals the programmed ID. In that cycle `addr_par` equals the correct parity XOR the address mask.
- R5: When the source ID does not match, parity is driven uncorrupted and the channel stays armed.
- R6: The arm bit reads 0 after the clock edge that ends the cycle in which the channel fired. Later matching cycles carry correct parity.
- R7: The data channel fires only on the first beat of a burst. A burst ends with a data beat that has `txn_last`=1. Later beats carry correct parity and do not use up the shot.
- R8: An address cycle neither corrupts nor disarms the data channel. A data beat neither corrupts nor disarms the address channel.
- R9: An all-zero mask with the channel armed uses up the shot and leaves parity correct.
- R10: A control-register write in the same cycle as a fire sets the arm bit to the written value.
- R11: With `txn_valid`=0 no fault is driven and both channels stay armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| txn_valid | input | 1 | Bus cycle present this clock |
| txn_is_data | input | 1 | 1 = data beat, 0 = address cycle |
| txn_last | input | 1 | Data beat closes its burst |
| txn_src | input | 5 | Source ID of the address or data |
| txn_addr | input | 36 | Address being driven |
| txn_data | input | 128 | Data being driven |
| addr_par | output | 5 | Address parity, possibly corrupted |
| data_par | output | 16 | Data parity, possibly corrupted |

## Verification
The bench arms the data channel in the middle of a burst. A design that treated any matching beat as a fire would corrupt a later beat and use up its shot there. The bench also crosses phases, sending an address cycle to the armed data channel and a data beat to the armed address channel. A design that shared the window logic would disarm the wrong channel. A control write that lands in the same cycle as a fire must keep the channel armed, and a design that let hardware win would drop the rearm. An all-zero mask and a valid-low cycle that matches the ID check that the shot is used up, or kept, as R9 and R11 require.

// File: rtl/bpi_pkg.sv
package bpi_pkg;
    typedef enum logic { ARM_IDLE = 1'b0, ARM_LIVE = 1'b1 } arm_state_t;
    typedef enum logic { BEAT_FIRST = 1'b0, BEAT_REST = 1'b1 } beat_state_t;
endpackage

// File: rtl/bpi_parity_gen.sv
module bpi_parity_gen #(
    parameter int W = 36
) (
    input  logic [W-1:0]         din,
    output logic [(W+7)/8-1:0]   par
);
    localparam int NG = (W + 7) / 8;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = g * 8;
        localparam int HI = (g * 8 + 7 < W) ? g * 8 + 7 : W - 1;
        assign par[g] = ^din[HI:LO];
    end
endmodule

// File: rtl/bpi_beat_tracker.sv
module bpi_beat_tracker
    import bpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic last,
    output logic first
);
    beat_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BEAT_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BEAT_FIRST: if (beat && !last) state_d = BEAT_REST;
            BEAT_REST:  if (beat && last)  state_d = BEAT_FIRST;
            default:    state_d = BEAT_FIRST;
        endcase
    end

    always_comb first = (state_q == BEAT_FIRST);

    AST_BURST_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last) |=> first); // R7
endmodule

// File: rtl/bpi_inj_channel.sv
module bpi_inj_channel
    import bpi_pkg::*;
#(
    parameter int PW   = 5,
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we,
    input  logic            ctrl_we,
    input  logic [PW-1:0]   mask_wdata,
    input  logic            arm_wdata,
    input  logic [ID_W-1:0] id_wdata,
    input  logic            window,
    input  logic [ID_W-1:0] src_id,
    output logic [PW-1:0]   mask_q,
    output logic [ID_W-1:0] id_q,
    output logic            armed,
    output logic [PW-1:0]   flip
);
    arm_state_t state_q, state_d;
    logic       fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
            mask_q  <= '0;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (mask_we) mask_q <= mask_wdata;
            if (ctrl_we) id_q   <= id_wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (ctrl_we && arm_wdata) state_d = ARM_LIVE;
            ARM_LIVE: begin
                if (ctrl_we)   state_d = arm_wdata ? ARM_LIVE : ARM_IDLE;
                else if (fire) state_d = ARM_IDLE;
            end
            default: state_d = ARM_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == ARM_LIVE);
        fire  = armed && window && (src_id == id_q);
        flip  = fire ? mask_q : '0;
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ctrl_we) |=> !armed); // R6
    AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (armed == $past(arm_wdata))); // R10
    AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (flip != '0) |-> (window && src_id == id_q)); // R5
endmodule

// File: rtl/bus_parity_injector.sv
module bus_parity_injector #(
    parameter int ADDR_W = 36,
    parameter int DATA_W = 128,
    parameter int ID_W   = 5,
    parameter int REG_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [1:0]              reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    input  logic                    txn_valid,
    input  logic                    txn_is_data,
    input  logic                    txn_last,
    input  logic [ID_W-1:0]         txn_src,
    input  logic [ADDR_W-1:0]       txn_addr,
    input  logic [DATA_W-1:0]       txn_data,
    output logic [(ADDR_W+7)/8-1:0] addr_par,
    output logic [(DATA_W+7)/8-1:0] data_par
);
    localparam int AP_W   = (ADDR_W + 7) / 8;
    localparam int DP_W   = (DATA_W + 7) / 8;
    localparam int ID_LSB = 8;

    localparam logic [1:0] RA_AMASK = 2'd0;
    localparam logic [1:0] RA_ACTRL = 2'd1;
    localparam logic [1:0] RA_DMASK = 2'd2;
    localparam logic [1:0] RA_DCTRL = 2'd3;

    logic [AP_W-1:0] a_good, a_flip, a_mask;
    logic [DP_W-1:0] d_good, d_flip, d_mask;
    logic [ID_W-1:0] a_id, d_id;
    logic            a_armed, d_armed, d_first;
    logic            a_window, d_window;

    bpi_parity_gen #(.W(ADDR_W)) u_apar (.din(txn_addr), .par(a_good));
    bpi_parity_gen #(.W(DATA_W)) u_dpar (.din(txn_data), .par(d_good));

    bpi_beat_tracker u_beat (
        .clk(clk), .rst_n(rst_n),
        .beat(txn_valid && txn_is_data), .last(txn_last), .first(d_first)
    );

    always_comb begin
        a_window = txn_valid && !txn_is_data;
        d_window = txn_valid && txn_is_data && d_first;
    end

    bpi_inj_channel #(.PW(AP_W), .ID_W(ID_W)) u_ach (
        .clk(clk), .rst_n(rst_n),
        .mask_we(reg_we && reg_addr == RA_AMASK),
        .ctrl_we(reg_we && reg_addr == RA_ACTRL),
        .mask_wdata(reg_wdata[AP_W-1:0]),
        .arm_wdata(reg_wdata[0]),
        .id_wdata(reg_wdata[ID_LSB+ID_W-1:ID_LSB]),
        .window(a_window), .src_id(txn_src),
        .mask_q(a_mask), .id_q(a_id), .armed(a_armed), .flip(a_flip)
    );

    bpi_inj_channel #(.PW(DP_W), .ID_W(ID_W)) u_dch (
        .clk(clk), .rst_n(rst_n),
        .mask_we(reg_we && reg_addr == RA_DMASK),
        .ctrl_we(reg_we && reg_addr == RA_DCTRL),
        .mask_wdata(reg_wdata[DP_W-1:0]),
        .arm_wdata(reg_wdata[0]),
        .id_wdata(reg_wdata[ID_LSB+ID_W-1:ID_LSB]),
        .window(d_window), .src_id(txn_src),
        .mask_q(d_mask), .id_q(d_id), .armed(d_armed), .flip(d_flip)
    );

    always_comb begin
        addr_par = a_good ^ a_flip;
        data_par = d_good ^ d_flip;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_AMASK: reg_rdata[AP_W-1:0] = a_mask;
            RA_ACTRL: begin
                reg_rdata[ID_LSB+ID_W-1:ID_LSB] = a_id;
                reg_rdata[0] = a_armed;
            end
            RA_DMASK: reg_rdata[DP_W-1:0] = d_mask;
            RA_DCTRL: begin
                reg_rdata[ID_LSB+ID_W-1:ID_LSB] = d_id;
                reg_rdata[0] = d_armed;
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_ADDR_FAULT_IN_ADDR_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_par != a_good) |-> (txn_valid && !txn_is_data && a_armed)); // R8
    AST_DATA_FAULT_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_par != d_good) |-> (txn_valid && txn_is_data && d_first && d_armed)); // R7
endmodule

// File: tb/sim_bus_parity_injector.sv
`timescale 1ns/1ps
module sim_bus_parity_injector;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         reg_we;
    logic [1:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic         txn_valid, txn_is_data, txn_last;
    logic [4:0]   txn_src;
    logic [35:0]  txn_addr;
    logic [127:0] txn_data;
    logic [4:0]   addr_par;
    logic [15:0]  data_par;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    bus_parity_injector u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_valid(txn_valid),
        .txn_is_data(txn_is_data), .txn_last(txn_last), .txn_src(txn_src),
        .txn_addr(txn_addr), .txn_data(txn_data), .addr_par(addr_par),
        .data_par(data_par)
    );

    localparam int NV = 4;
    localparam logic [35:0]  VA [NV] = '{36'h0, 36'hF_FFFF_FFFF, 36'h1_0000_0001, 36'h8_0703_0100};
    localparam logic [4:0]   VAP[NV] = '{5'b00000, 5'b00000, 5'b10001, 5'b11010};
    localparam logic [127:0] VD [NV] = '{128'h0, {128{1'b1}}, 128'h0301,
                                         {4'h8, 120'h0, 4'h1}};
    localparam logic [15:0]  VDP[NV] = '{16'h0000, 16'h0000, 16'h0001, 16'h8001};

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic bus(input logic isd, input logic last, input logic [4:0] id,
                       input logic [35:0] a, input logic [127:0] d);
        @(negedge clk);
        txn_valid = 1'b1; txn_is_data = isd; txn_last = last;
        txn_src = id; txn_addr = a; txn_data = d;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        txn_valid = 1'b0;
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        txn_valid = 1'b0; txn_is_data = 1'b0; txn_last = 1'b0;
        txn_src = '0; txn_addr = '0; txn_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R3 reset state
        for (int i = 0; i < 4; i++) begin
            rd(i[1:0], r);
            chk("R3 reset register", r, 0);
        end

        // R1 R2 vector table
        for (int i = 0; i < NV; i++) begin
            bus(1'b0, 1'b0, 5'd0, VA[i], VD[i]);
            chk("R1 address parity", addr_par, VAP[i]);
            chk("R2 data parity", data_par, VDP[i]);
        end
        idle();

        // R3 readback
        wr(2'd0, 32'h15);
        wr(2'd1, 32'h0000_0301);
        rd(2'd0, r); chk("R3 addr mask readback", r, 32'h15);
        rd(2'd1, r); chk("R3 addr ctrl readback", r, 32'h301);

        // R5 mismatched ID
        bus(1'b0, 1'b0, 5'd5, VA[3], VD[0]);
        chk("R5 mismatch parity clean", addr_par, VAP[3]);
        idle();
        rd(2'd1, r); chk("R5 still armed", r, 32'h301);

        // R4 fire, R6 one shot
        bus(1'b0, 1'b0, 5'd3, VA[3], VD[0]);
        chk("R4 addr fault", addr_par, VAP[3] ^ 5'b10101);
        idle();
        rd(2'd1, r); chk("R6 arm cleared", r, 32'h300);
        bus(1'b0, 1'b0, 5'd3, VA[3], VD[0]);
        chk("R6 second cycle clean", addr_par, VAP[3]);
        idle();

        // R8 cross-phase isolation
        wr(2'd2, 32'h00F0);
        wr(2'd3, 32'h0000_0201);
        wr(2'd1, 32'h0000_0201);
        bus(1'b0, 1'b0, 5'd2, VA[0], VD[2]);
        chk("R8 addr cycle leaves data parity", data_par, VDP[2]);
        chk("R4 addr fault id 2", addr_par, VAP[0] ^ 5'b10101);
        idle();
        rd(2'd3, r); chk("R8 data still armed", r, 32'h201);
        wr(2'd1, 32'h0000_0201);
        bus(1'b1, 1'b0, 5'd2, VA[0], VD[2]);
        chk("R7 first beat fault", data_par, VDP[2] ^ 16'h00F0);
        chk("R8 data beat leaves addr parity", addr_par, VAP[0]);
        bus(1'b1, 1'b1, 5'd2, VA[0], VD[2]);
        chk("R7 second beat clean", data_par, VDP[2]);
        idle();
        rd(2'd1, r); chk("R8 addr still armed", r, 32'h201);
        rd(2'd3, r); chk("R6 data arm cleared", r, 32'h200);
        wr(2'd1, 32'h0);

        // R7 armed mid-burst
        bus(1'b1, 1'b0, 5'd7, VA[0], VD[3]);
        idle();
        wr(2'd3, 32'h0000_0701);
        bus(1'b1, 1'b1, 5'd7, VA[0], VD[3]);
        chk("R7 later beat clean", data_par, VDP[3]);
        idle();
        rd(2'd3, r); chk("R7 shot kept past later beat", r, 32'h701);
        bus(1'b1, 1'b1, 5'd7, VA[0], VD[3]);
        chk("R7 next burst first beat fault", data_par, VDP[3] ^ 16'h00F0);
        idle();

        // R9 zero mask
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0000_0101);
        bus(1'b1, 1'b1, 5'd1, VA[0], VD[3]);
        chk("R9 zero mask clean", data_par, VDP[3]);
        idle();
        rd(2'd3, r); chk("R9 shot consumed", r, 32'h100);

        // R10 software write wins
        wr(2'd0, 32'h1);
        wr(2'd1, 32'h0000_0401);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0401;
        txn_valid = 1'b1; txn_is_data = 1'b0; txn_last = 1'b0;
        txn_src = 5'd4; txn_addr = VA[2]; txn_data = VD[0];
        #2;
        chk("R10 fault during rewrite", addr_par, VAP[2] ^ 5'b00001);
        @(negedge clk);
        reg_we = 1'b0; txn_valid = 1'b0;
        #2;
        rd(2'd1, r); chk("R10 write wins", r, 32'h401);

        // R11 valid low
        @(negedge clk);
        txn_valid = 1'b0; txn_is_data = 1'b0; txn_src = 5'd4; txn_addr = VA[2];
        #2;
        chk("R11 no fault when idle", addr_par, VAP[2]);
        idle();
        rd(2'd1, r); chk("R11 stays armed", r, 32'h401);
        bus(1'b0, 1'b0, 5'd4, VA[2], VD[0]);
        chk("R4 fault after rearm", addr_par, VAP[2] ^ 5'b00001);
        idle();
        rd(2'd1, r); chk("R6 cleared after rearm", r, 32'h400);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule